// File: doc/BRIEF.md
# Chunk ECC Syndrome Classifier and Byte Corrector

This block takes two 22-bit error-check codes for one 256-byte chunk of flash data: the code worked out over the data as it arrived, and the code that was stored next to that data. Their bitwise XOR is the syndrome. From the syndrome the block decides whether the chunk is clean, whether only the stored code is damaged, whether a single data bit can be repaired, or whether the damage is too large to repair. For a repairable error it gives the byte index within the chunk and the bit index within that byte.

The block also holds a local page buffer of one or more chunks. When it finds a repairable error, it reads the addressed byte back from that buffer and writes it again with the failing bit flipped. This read-modify-write takes two cycles. On a two-chunk page, the host checks the chunks one after the other, and the block keeps a page failure flag that collects the results of the chunks.

Top module: `hamming_chunk_corrector`

## Requirements
- R1: While reset is held and after it is released, `done`, `status`, `fail_byte`, `fail_bit`, `page_fail` and `fix_busy` are all zero.
- R2: The result of an accepted `start` is registered at the clock edge that samples it. `done` is high for exactly the one cycle after that edge. `status`, `fail_byte` and `fail_bit` then hold their values until the next accepted start.
- R3: If the syndrome is zero, or if either code is all zeros, `status` is 0 (clean). `fail_byte` and `fail_bit` are 0 and the buffer is left unchanged, even when the syndrome would otherwise look repairable.
- R4: If exactly one syndrome bit is set, and neither code is zero, `status` is 1 (only the stored code is in error). `fail_byte` and `fail_bit` are 0 and the buffer is left unchanged.
- R5: A syndrome is repairable when exactly 11 of its bits are set and its bits 10:0 XOR its bits 21:11 equal 0x7FF. A repairable syndrome gives `status` 2. `fail_bit` is then syndrome bits 2:0 and `fail_byte` is syndrome bits 10:3.
- R6: Any other syndrome gives `status` 3 (uncorrectable). This includes a syndrome with 11 bits set whose halves are not exact complements. `fail_byte` and `fail_bit` are 0 and the buffer is left unchanged.
- R7: On status 2, the buffer byte at address `chunk_sel`*256 + `fail_byte` is XORed with 1 shifted left by `fail_bit`. `fix_busy` is high for the two cycles after the accepting edge: one cycle to read, one cycle to write. No other byte changes.
- R8: A chunk fails when its status is 1 or 3. An accepted start with `chunk_sel` = 0 sets `page_fail` to that chunk's failure. An accepted start with any other `chunk_sel` ORs that chunk's failure into `page_fail`.
- R9: A `start` sampled while `fix_busy` is high is ignored. No `done` follows, and `status`, `fail_byte`, `fail_bit` and `page_fail` keep their values.
- R10: A host write (`buf_we`) stores `buf_wdata` at `buf_waddr` while `fix_busy` is low, and is dropped while `fix_busy` is high. `buf_rdata` returns the byte at `buf_raddr` one cycle after the address is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | One-cycle request to check one chunk |
| chunk_sel | input | 1 | Index of the chunk within the page |
| calc_code | input | 22 | Code computed over the received chunk |
| stored_code | input | 22 | Code read back with the chunk |
| done | output | 1 | Result valid pulse |
| status | output | 2 | 0 clean, 1 code-only error, 2 repaired, 3 uncorrectable |
| fail_byte | output | 8 | Byte index of the repaired bit within the chunk |
| fail_bit | output | 3 | Bit index of the repaired bit within the byte |
| page_fail | output | 1 | Failure accumulated over the chunks of the page |
| fix_busy | output | 1 | Buffer read-modify-write in progress |
| buf_we | input | 1 | Host buffer write enable |
| buf_waddr | input | 9 | Host buffer write address |
| buf_wdata | input | 8 | Host buffer write data |
| buf_raddr | input | 9 | Host buffer read address |
| buf_rdata | output | 8 | Registered host buffer read data |

## Verification
Random code pairs almost never land in the repairable class. A syndrome must have exactly 11 bits set and also have complementary halves, so random stimulus would leave R5 and R7 nearly untested. The bench therefore builds each syndrome from a chosen byte and bit index, and it sweeps every one of the 2048 locations in both chunks. It also builds the near misses by hand: syndromes with 11 bits set but halves that are not complements, and repairable-looking syndromes where one code is zero. The overlap case in R9 and R10 can only be reached with precise timing. The bench drives a second start and a host write in the single cycle right after a repair is accepted.

// File: rtl/hcc_pkg.sv
package hcc_pkg;

   typedef enum logic [1:0] {
      ST_CLEAN    = 2'd0,
      ST_CODE_ERR = 2'd1,
      ST_FIXED    = 2'd2,
      ST_UNCORR   = 2'd3
   } chk_status_e;

   typedef enum logic [1:0] {
      FX_IDLE  = 2'd0,
      FX_READ  = 2'd1,
      FX_WRITE = 2'd2
   } fix_state_e;

   function automatic logic is_chunk_failure(chk_status_e s);
      return (s == ST_CODE_ERR) || (s == ST_UNCORR);
   endfunction

endpackage

// File: rtl/hcc_classify.sv
module hcc_classify
   import hcc_pkg::*;
#(
   parameter int HALF_W    = 11,
   parameter int BIT_IDX_W = 3
) (
   input  logic [2*HALF_W-1:0]           calc_code,
   input  logic [2*HALF_W-1:0]           stored_code,
   output chk_status_e                   cls_status,
   output logic [HALF_W-BIT_IDX_W-1:0]   cls_byte,
   output logic [BIT_IDX_W-1:0]          cls_bit
);
   localparam int CODE_W   = 2 * HALF_W;
   localparam int WEIGHT_W = $clog2(CODE_W + 1);

   logic [CODE_W-1:0]   syn;
   logic [HALF_W-1:0]   syn_lo;
   logic [HALF_W-1:0]   syn_hi;
   logic [WEIGHT_W-1:0] weight;
   logic                halves_complement;
   logic                any_code_zero;

   assign syn    = calc_code ^ stored_code;
   assign syn_lo = syn[HALF_W-1:0];
   assign syn_hi = syn[CODE_W-1:HALF_W];

   // The combined parity check is the same as the two syndrome halves being complements
   assign halves_complement = &(syn_lo ^ syn_hi);
   assign any_code_zero     = (calc_code == '0) || (stored_code == '0);

   always_comb begin
      weight = '0;
      for (int i = 0; i < CODE_W; i++) begin
         weight = weight + WEIGHT_W'(syn[i]);
      end
   end

   always_comb begin
      if ((syn == '0) || any_code_zero) begin
         cls_status = ST_CLEAN;
      end else if (weight == WEIGHT_W'(1)) begin
         cls_status = ST_CODE_ERR;
      end else if ((weight == WEIGHT_W'(HALF_W)) && halves_complement) begin
         cls_status = ST_FIXED;
      end else begin
         cls_status = ST_UNCORR;
      end
   end

   always_comb begin
      if (cls_status == ST_FIXED) begin
         cls_bit  = syn_lo[BIT_IDX_W-1:0];
         cls_byte = syn_lo[HALF_W-1:BIT_IDX_W];
      end else begin
         cls_bit  = '0;
         cls_byte = '0;
      end
   end

endmodule

// File: rtl/hcc_result.sv
module hcc_result
   import hcc_pkg::*;
#(
   parameter int BYTE_IDX_W = 8,
   parameter int BIT_IDX_W  = 3,
   parameter int SEL_W      = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  accept,
   input  logic [SEL_W-1:0]      chunk_sel,
   input  chk_status_e           cls_status,
   input  logic [BYTE_IDX_W-1:0] cls_byte,
   input  logic [BIT_IDX_W-1:0]  cls_bit,
   output logic                  done,
   output chk_status_e           status_q,
   output logic [BYTE_IDX_W-1:0] byte_q,
   output logic [BIT_IDX_W-1:0]  bit_q,
   output logic                  page_fail
);
   logic chunk_fail;
   logic first_chunk;

   assign chunk_fail  = is_chunk_failure(cls_status);
   assign first_chunk = (chunk_sel == '0);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done      <= 1'b0;
         status_q  <= ST_CLEAN;
         byte_q    <= '0;
         bit_q     <= '0;
         page_fail <= 1'b0;
      end else begin
         done <= accept;
         if (accept) begin
            status_q  <= cls_status;
            byte_q    <= cls_byte;
            bit_q     <= cls_bit;
            page_fail <= first_chunk ? chunk_fail : (page_fail | chunk_fail);
         end
      end
   end

endmodule

// File: rtl/hcc_fix_buffer.sv
module hcc_fix_buffer
   import hcc_pkg::*;
#(
   parameter int ADDR_W = 9,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fix_req,
   input  logic [ADDR_W-1:0] fix_addr,
   input  logic [DATA_W-1:0] fix_mask,
   input  logic              host_we,
   input  logic [ADDR_W-1:0] host_waddr,
   input  logic [DATA_W-1:0] host_wdata,
   input  logic [ADDR_W-1:0] host_raddr,
   output logic [DATA_W-1:0] host_rdata,
   output logic              busy
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];
   fix_state_e        state;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] mask_q;
   logic [DATA_W-1:0] old_q;

   assign busy = (state != FX_IDLE);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state  <= FX_IDLE;
         addr_q <= '0;
         mask_q <= '0;
      end else begin
         unique case (state)
            FX_IDLE: begin
               if (fix_req) begin
                  state  <= FX_READ;
                  addr_q <= fix_addr;
                  mask_q <= fix_mask;
               end
            end
            FX_READ:  state <= FX_WRITE;
            FX_WRITE: state <= FX_IDLE;
            default:  state <= FX_IDLE;
         endcase
      end
   end

   // storage: the repair write takes the write port, and host writes are dropped while busy
   always_ff @(posedge clk) begin
      if (state == FX_READ) begin
         old_q <= mem[addr_q];
      end
      if (state == FX_WRITE) begin
         mem[addr_q] <= old_q ^ mask_q;
      end else if ((state == FX_IDLE) && host_we) begin
         mem[host_waddr] <= host_wdata;
      end
      host_rdata <= mem[host_raddr];
   end

endmodule

// File: rtl/hamming_chunk_corrector.sv
module hamming_chunk_corrector
   import hcc_pkg::*;
#(
   parameter int HALF_W     = 11,
   parameter int BIT_IDX_W  = 3,
   parameter int NUM_CHUNKS = 2,
   localparam int CODE_W     = 2 * HALF_W,
   localparam int BYTE_IDX_W = HALF_W - BIT_IDX_W,
   localparam int DATA_W     = 1 << BIT_IDX_W,
   localparam int CHUNK_BYTES = 1 << BYTE_IDX_W,
   localparam int BUF_BYTES  = NUM_CHUNKS * CHUNK_BYTES,
   localparam int ADDR_W     = $clog2(BUF_BYTES),
   localparam int SEL_W      = (NUM_CHUNKS > 1) ? $clog2(NUM_CHUNKS) : 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic [SEL_W-1:0]      chunk_sel,
   input  logic [CODE_W-1:0]     calc_code,
   input  logic [CODE_W-1:0]     stored_code,
   output logic                  done,
   output logic [1:0]            status,
   output logic [BYTE_IDX_W-1:0] fail_byte,
   output logic [BIT_IDX_W-1:0]  fail_bit,
   output logic                  page_fail,
   output logic                  fix_busy,
   input  logic                  buf_we,
   input  logic [ADDR_W-1:0]     buf_waddr,
   input  logic [DATA_W-1:0]     buf_wdata,
   input  logic [ADDR_W-1:0]     buf_raddr,
   output logic [DATA_W-1:0]     buf_rdata
);

   if (BIT_IDX_W < 1 || HALF_W <= BIT_IDX_W) begin : g_bad_split
      $error("HALF_W must exceed BIT_IDX_W, and BIT_IDX_W must be at least 1");
   end
   if (NUM_CHUNKS < 1 || (NUM_CHUNKS & (NUM_CHUNKS - 1)) != 0) begin : g_bad_chunks
      $error("NUM_CHUNKS must be a power of two");
   end

   chk_status_e           cls_status;
   chk_status_e           status_q;
   logic [BYTE_IDX_W-1:0] cls_byte;
   logic [BIT_IDX_W-1:0]  cls_bit;
   logic                  accept;
   logic                  fix_req;
   logic [ADDR_W-1:0]     fix_addr;
   logic [DATA_W-1:0]     fix_mask;

   assign accept   = start && !fix_busy;
   assign fix_req  = accept && (cls_status == ST_FIXED);
   assign fix_mask = DATA_W'(1) << cls_bit;
   assign status   = status_q;

   if (NUM_CHUNKS == 1) begin : g_single_chunk
      assign fix_addr = ADDR_W'(cls_byte);
   end else begin : g_multi_chunk
      assign fix_addr = {chunk_sel, cls_byte};
   end

   hcc_classify #(
      .HALF_W    (HALF_W),
      .BIT_IDX_W (BIT_IDX_W)
   ) u_classify (
      .calc_code   (calc_code),
      .stored_code (stored_code),
      .cls_status  (cls_status),
      .cls_byte    (cls_byte),
      .cls_bit     (cls_bit)
   );

   hcc_result #(
      .BYTE_IDX_W (BYTE_IDX_W),
      .BIT_IDX_W  (BIT_IDX_W),
      .SEL_W      (SEL_W)
   ) u_result (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .chunk_sel  (chunk_sel),
      .cls_status (cls_status),
      .cls_byte   (cls_byte),
      .cls_bit    (cls_bit),
      .done       (done),
      .status_q   (status_q),
      .byte_q     (fail_byte),
      .bit_q      (fail_bit),
      .page_fail  (page_fail)
   );

   hcc_fix_buffer #(
      .ADDR_W (ADDR_W),
      .DATA_W (DATA_W)
   ) u_fix_buffer (
      .clk        (clk),
      .rst_n      (rst_n),
      .fix_req    (fix_req),
      .fix_addr   (fix_addr),
      .fix_mask   (fix_mask),
      .host_we    (buf_we),
      .host_waddr (buf_waddr),
      .host_wdata (buf_wdata),
      .host_raddr (buf_raddr),
      .host_rdata (buf_rdata),
      .busy       (fix_busy)
   );

endmodule

// File: rtl/hcc_checker.sv
module hcc_checker #(
   parameter int CODE_W = 22
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic [CODE_W-1:0] calc_code,
   input logic [CODE_W-1:0] stored_code,
   input logic              done,
   input logic [1:0]        status,
   input logic              page_fail,
   input logic              fix_busy
);

   p_done_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> $past(start));

   p_match_is_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(calc_code == stored_code)) |-> (status == 2'd0));

   p_code_err_single_bit_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (done && status == 2'd1) |-> ($past($countones(calc_code ^ stored_code)) == 1));

   p_repair_runs_r7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (fix_busy == (status == 2'd2)));

   p_page_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (done && (status == 2'd1 || status == 2'd3)) |-> page_fail);

   p_busy_start_dropped_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $past(start && fix_busy) |-> !done);

endmodule

bind hamming_chunk_corrector hcc_checker #(.CODE_W(CODE_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start       (start),
   .calc_code   (calc_code),
   .stored_code (stored_code),
   .done        (done),
   .status      (status),
   .page_fail   (page_fail),
   .fix_busy    (fix_busy)
);

// File: tb/sim_hamming_chunk_corrector.sv
`timescale 1ns/1ps
module sim_hamming_chunk_corrector;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [0:0]  chunk_sel = '0;
   logic [21:0] calc_code = '0;
   logic [21:0] stored_code = '0;
   logic        done;
   logic [1:0]  status;
   logic [7:0]  fail_byte;
   logic [2:0]  fail_bit;
   logic        page_fail;
   logic        fix_busy;
   logic        buf_we = 1'b0;
   logic [8:0]  buf_waddr = '0;
   logic [7:0]  buf_wdata = '0;
   logic [8:0]  buf_raddr = '0;
   logic [7:0]  buf_rdata;

   int checks = 0;
   int failures = 0;
   bit finished = 0;
   logic [7:0] model [512];

   logic        o_done, o_done2, o_busy, o_page;
   logic [1:0]  o_status;
   logic [7:0]  o_byte;
   logic [2:0]  o_bit;

   always #2.5 clk = ~clk;

   hamming_chunk_corrector u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .chunk_sel(chunk_sel),
      .calc_code(calc_code), .stored_code(stored_code), .done(done),
      .status(status), .fail_byte(fail_byte), .fail_bit(fail_bit),
      .page_fail(page_fail), .fix_busy(fix_busy), .buf_we(buf_we),
      .buf_waddr(buf_waddr), .buf_wdata(buf_wdata), .buf_raddr(buf_raddr),
      .buf_rdata(buf_rdata)
   );

   task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // called on a falling edge; returns on the falling edge after the repair window
   task automatic run_chunk(logic sel, logic [21:0] c, logic [21:0] s);
      start = 1'b1; chunk_sel = sel; calc_code = c; stored_code = s;
      @(negedge clk);
      start = 1'b0;
      o_done = done; o_status = status; o_byte = fail_byte; o_bit = fail_bit;
      o_busy = fix_busy; o_page = page_fail;
      @(negedge clk);
      o_done2 = done;
      @(negedge clk);
   endtask

   task automatic read_buf(logic [8:0] a, output logic [7:0] d);
      buf_raddr = a;
      @(negedge clk);
      d = buf_rdata;
   endtask

   task automatic expect_result(string tag, logic [1:0] st, logic [7:0] b, logic [2:0] t, logic pf);
      logic [31:0] act, exp;
      act = {16'h0, o_done, o_done2, o_busy, o_page, o_status, o_byte[7:0], o_bit, 1'b0};
      exp = {16'h0, 1'b1, 1'b0, (st == 2'd2), pf, st, b, t, 1'b0};
      check(act == exp, tag, act, exp);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!finished) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [7:0]  rd;
      logic [21:0] c, syn;
      logic [10:0] lo;

      repeat (4) @(negedge clk);
      check({done, status, fail_byte, fail_bit, page_fail, fix_busy} == '0,
            "R1 outputs in reset", {done, status, fail_byte, fail_bit, page_fail, fix_busy}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check({done, status, fail_byte, fail_bit, page_fail, fix_busy} == '0,
            "R1 outputs after reset", {done, status, fail_byte, fail_bit, page_fail, fix_busy}, 0);

      // R10: load the whole buffer with a known image
      for (int a = 0; a < 512; a++) begin
         model[a] = 8'((a * 37 + 11) & 8'hFF);
         buf_we = 1'b1; buf_waddr = 9'(a); buf_wdata = model[a];
         @(negedge clk);
      end
      buf_we = 1'b0;
      read_buf(9'd300, rd);
      check(rd == model[300], "R10 host write readback", rd, model[300]);

      // R5 R7 R2: every byte and bit location in both chunks
      for (int sel = 0; sel < 2; sel++) begin
         for (int b = 0; b < 256; b++) begin
            for (int t = 0; t < 8; t++) begin
               lo  = {8'(b), 3'(t)};
               syn = {~lo, lo};
               c   = {11'(b * 3 + 1), 11'(b * 3 + 1)};
               run_chunk(1'(sel), c, c ^ syn);
               expect_result($sformatf("R5 R2 repair sel=%0d byte=%0d bit=%0d", sel, b, t),
                             2'd2, 8'(b), 3'(t), 1'b0);
               model[sel * 256 + b] = model[sel * 256 + b] ^ (8'd1 << t);
            end
         end
      end
      read_buf(9'd256 + 9'd77, rd);
      check(rd == model[333], "R7 repaired byte in second chunk", rd, model[333]);

      // R2: outputs held after done falls
      run_chunk(1'b0, 22'h0ABCDE, 22'h0ABCDE ^ {~11'h123, 11'h123});
      check(done == 1'b0 && status == 2'd2 && fail_byte == 8'h24 && fail_bit == 3'd3,
            "R2 outputs held", {done, status, fail_byte, fail_bit}, {1'b0, 2'd2, 8'h24, 3'd3});
      model[9'h024] = model[9'h024] ^ 8'h08;

      // R4: one-bit syndrome at every position
      for (int k = 0; k < 22; k++) begin
         run_chunk(1'b0, 22'h2C3A5F, 22'h2C3A5F ^ (22'd1 << k));
         expect_result($sformatf("R4 code-only bit %0d", k), 2'd1, 8'd0, 3'd0, 1'b1);
      end

      // R3: equal codes, zero calc, zero stored (even repair-shaped)
      for (int k = 0; k < 8; k++) begin
         c = 22'h15A3C7 ^ (22'h3 << (k * 2));
         run_chunk(1'(k & 1), c, c);
         expect_result($sformatf("R3 equal codes %0d", k), 2'd0, 8'd0, 3'd0, 1'b0);
      end
      run_chunk(1'b0, 22'h0, 22'h000004);
      expect_result("R3 calc zero", 2'd0, 8'd0, 3'd0, 1'b0);
      run_chunk(1'b0, {~11'h0F5, 11'h0F5}, 22'h0);
      expect_result("R3 stored zero repair-shaped", 2'd0, 8'd0, 3'd0, 1'b0);
      run_chunk(1'b0, 22'h0, {~11'h0F5, 11'h0F5});
      expect_result("R3 calc zero repair-shaped", 2'd0, 8'd0, 3'd0, 1'b0);

      // R6: uncorrectable shapes
      for (int k = 0; k < 21; k++) begin
         run_chunk(1'b0, 22'h1E2D3C, 22'h1E2D3C ^ (22'd3 << k));
         expect_result($sformatf("R6 two-bit at %0d", k), 2'd3, 8'd0, 3'd0, 1'b1);
      end
      run_chunk(1'b0, 22'h1E2D3C, 22'h1E2D3C ^ {11'h001, 11'h3FF});
      expect_result("R6 eleven bits halves not complement", 2'd3, 8'd0, 3'd0, 1'b1);
      run_chunk(1'b0, 22'h1E2D3C, 22'h1E2D3C ^ {11'h001, 11'h7FF});
      expect_result("R6 twelve bits", 2'd3, 8'd0, 3'd0, 1'b1);
      run_chunk(1'b0, 22'h1E2D3C, 22'h1E2D3C ^ {11'h7FF, 11'h3FF});
      expect_result("R6 twenty-one bits", 2'd3, 8'd0, 3'd0, 1'b1);

      // R8: page accumulation
      run_chunk(1'b0, 22'h111111, 22'h111111);
      run_chunk(1'b1, 22'h111111, 22'h111113);
      check(o_page == 1'b1, "R8 second chunk code error sets page", o_page, 1);
      run_chunk(1'b0, 22'h111111, 22'h111111);
      check(o_page == 1'b0, "R8 first chunk clean restarts page", o_page, 0);
      run_chunk(1'b0, 22'h111111, 22'h111111 ^ 22'h30);
      run_chunk(1'b1, 22'h111111, 22'h111111);
      check(o_page == 1'b1, "R8 failure kept across clean second chunk", o_page, 1);
      run_chunk(1'b0, 22'h222222, 22'h222222 ^ {~11'h010, 11'h010});
      model[9'h002] = model[9'h002] ^ 8'h01;
      check(o_page == 1'b0 && o_status == 2'd2, "R8 repaired chunk is not a failure",
            {o_page, o_status}, {1'b0, 2'd2});

      // R9 R10: second start and host write in the repair window
      start = 1'b1; chunk_sel = 1'b0; calc_code = 22'h0F0F0F;
      stored_code = 22'h0F0F0F ^ {~11'h02A, 11'h02A};
      @(negedge clk);
      check(fix_busy == 1'b1, "R7 busy after repair accepted", fix_busy, 1);
      calc_code = 22'h000777; stored_code = 22'h000776;
      buf_we = 1'b1; buf_waddr = 9'd100; buf_wdata = ~model[100];
      @(negedge clk);
      start = 1'b0; buf_we = 1'b0;
      check(done == 1'b0 && status == 2'd2 && fail_byte == 8'h05 && fail_bit == 3'd2,
            "R9 start while busy ignored", {done, status, fail_byte, fail_bit},
            {1'b0, 2'd2, 8'h05, 3'd2});
      @(negedge clk);
      model[9'h005] = model[9'h005] ^ 8'h04;
      read_buf(9'd100, rd);
      check(rd == model[100], "R10 host write dropped while busy", rd, model[100]);
      read_buf(9'd5, rd);
      check(rd == model[5], "R7 repair in window", rd, model[5]);
      buf_we = 1'b1; buf_waddr = 9'd100; buf_wdata = 8'hEE;
      @(negedge clk);
      buf_we = 1'b0;
      model[100] = 8'hEE;
      read_buf(9'd100, rd);
      check(rd == 8'hEE, "R10 host write when idle", rd, 8'hEE);

      // R7 R3 R4 R6: whole buffer image after all stimulus
      for (int a = 0; a < 512; a++) begin
         read_buf(9'(a), rd);
         check(rd == model[a], $sformatf("R7 buffer image addr %0d", a), rd, model[a]);
      end

      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule